// File: doc/BRIEF.md
# Two-Path Pre-Trade Risk Gate

The gate sits between an order decision engine and the order transmit path. Every candidate order gets a single-cycle screen on order size and price. A failing order is dropped at once with a reject pulse. A passing order goes into a hold line. While it waits there, a three-cycle check runs alongside it. This check projects the net position and the cumulative notional exposure with the order included and compares both against configured limits. If the projection breaks a limit while the order is still held, the order is removed and a cancel pulse is raised.

The hold depth is a parameter. When it is at least as long as the thorough check, no order that fails that check can leave. If the hold is configured shorter, the verdict can arrive after the order has already been released. In that case the order stays released and the late verdict is flagged with its own reason code. The running position and exposure that the gate reports count only released orders.

Top module: `risk_gate`

## Requirements
- R1: An order with quantity 0 or above `max_qty_i` is dropped. One clock edge after it is sampled, `rej_valid_o` pulses for one cycle with `rej_code_o` = 1 and the order's tag on `rej_tag_o`.
- R2: An order whose price lies outside the inclusive range `px_lo_i`..`px_hi_i` is dropped with `rej_code_o` = 2. When the quantity is also at fault, code 1 is reported.
- R3: An order that passes both checks and is sampled at edge n appears on `out_*` for one cycle after edge n+HOLD_CYC. Its side, quantity, price and tag are unchanged.
- R4: The projected net position is the sum of all earlier orders that passed the thorough check, plus this order. A buy (side 0) adds its quantity and a sell (side 1) subtracts it. If the magnitude of the projection exceeds `pos_limit_i`, `cxl_valid_o` pulses after edge n+3 with code 3 and the tag. With HOLD_CYC of 3 or more, the order never reaches `out_*`.
- R5: The projected exposure is the sum of quantity × price over the same orders. If it exceeds `credit_limit_i`, the cancel carries code 4. Exposure equal to the limit passes. When both limits fail, code 3 is reported.
- R6: An order sampled one cycle behind another is judged against a projection that already includes the earlier order, even though the earlier order has not yet been released.
- R7: `pos_o` and `expo_o` change only on the edge after an order is on `out_*`, by that order's signed quantity and notional. Rejected or cancelled orders leave them unchanged.
- R8: With HOLD_CYC below 3, a failing thorough check on an already released order raises a cancel pulse with code 5. The order is not withdrawn and stays counted in `pos_o`/`expo_o`.
- R9: After reset, all valid outputs are low and `pos_o` and `expo_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ord_valid_i | input | 1 | Candidate order present this cycle |
| ord_side_i | input | 1 | 0 buy, 1 sell |
| ord_qty_i | input | QTY_W | Order quantity |
| ord_px_i | input | PX_W | Order price |
| ord_tag_i | input | TAG_W | Sequence tag |
| max_qty_i | input | QTY_W | Largest allowed quantity |
| px_lo_i | input | PX_W | Lowest allowed price |
| px_hi_i | input | PX_W | Highest allowed price |
| pos_limit_i | input | POS_W | Limit on the magnitude of the net position |
| credit_limit_i | input | EXP_W | Limit on cumulative notional |
| out_valid_o | output | 1 | Released order valid |
| out_side_o | output | 1 | Released order side |
| out_qty_o | output | QTY_W | Released order quantity |
| out_px_o | output | PX_W | Released order price |
| out_tag_o | output | TAG_W | Released order tag |
| rej_valid_o | output | 1 | Fast-check reject pulse |
| rej_code_o | output | 3 | Reject reason (1 size, 2 price) |
| rej_tag_o | output | TAG_W | Tag of rejected order |
| cxl_valid_o | output | 1 | Thorough-check cancel pulse |
| cxl_code_o | output | 3 | Cancel reason (3 position, 4 credit, 5 late) |
| cxl_tag_o | output | TAG_W | Tag of cancelled order |
| pos_o | output | POS_W | Net position of released orders, two's complement |
| expo_o | output | EXP_W | Cumulative notional of released orders |

## Verification
The assertions assume that the limit inputs change only while reset is applied. They also assume the configuration is consistent: `px_lo_i` not above `px_hi_i`, and the accumulated sums not wrapping their widths. The bench follows this. Every limit is written together with the reset pulse that starts a scenario, and order values stay far below the widths. Under these assumptions the bounds on `pos_o` and `expo_o` and the legality of the released quantities and prices hold at all times. A second instance with a short hold line shares the stimulus, so that late verdicts can be observed.

// File: rtl/risk_gate_pkg.sv
package risk_gate_pkg;
  localparam int SLOW_LAT = 3;

  typedef enum logic [2:0] {
    RC_NONE   = 3'd0,
    RC_QTY    = 3'd1,
    RC_PX     = 3'd2,
    RC_POS    = 3'd3,
    RC_CREDIT = 3'd4,
    RC_LATE   = 3'd5
  } reason_e;
endpackage

// File: rtl/rg_fast_check.sv
module rg_fast_check
  import risk_gate_pkg::*;
#(
  parameter int QTY_W = 16,
  parameter int PX_W  = 16,
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ord_valid_i,
  input  logic             ord_side_i,
  input  logic [QTY_W-1:0] ord_qty_i,
  input  logic [PX_W-1:0]  ord_px_i,
  input  logic [TAG_W-1:0] ord_tag_i,
  input  logic [QTY_W-1:0] max_qty_i,
  input  logic [PX_W-1:0]  px_lo_i,
  input  logic [PX_W-1:0]  px_hi_i,
  output logic             pass_vld_o,
  output logic             pass_side_o,
  output logic [QTY_W-1:0] pass_qty_o,
  output logic [PX_W-1:0]  pass_px_o,
  output logic [TAG_W-1:0] pass_tag_o,
  output logic             rej_vld_o,
  output reason_e          rej_code_o,
  output logic [TAG_W-1:0] rej_tag_o
);
  logic qty_bad, px_bad;

  assign qty_bad = (ord_qty_i == '0) || (ord_qty_i > max_qty_i);
  assign px_bad  = (ord_px_i < px_lo_i) || (ord_px_i > px_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_vld_o  <= 1'b0;
      pass_side_o <= 1'b0;
      pass_qty_o  <= '0;
      pass_px_o   <= '0;
      pass_tag_o  <= '0;
      rej_vld_o   <= 1'b0;
      rej_code_o  <= RC_NONE;
      rej_tag_o   <= '0;
    end else begin
      pass_vld_o  <= ord_valid_i && !qty_bad && !px_bad;
      pass_side_o <= ord_side_i;
      pass_qty_o  <= ord_qty_i;
      pass_px_o   <= ord_px_i;
      pass_tag_o  <= ord_tag_i;
      rej_vld_o   <= ord_valid_i && (qty_bad || px_bad);
      rej_code_o  <= qty_bad ? RC_QTY : RC_PX;  // size fault wins
      rej_tag_o   <= ord_tag_i;
    end
  end
endmodule

// File: rtl/rg_slow_line.sv
module rg_slow_line
  import risk_gate_pkg::*;
#(
  parameter int QTY_W    = 16,
  parameter int PX_W     = 16,
  parameter int TAG_W    = 8,
  parameter int POS_W    = 24,
  parameter int EXP_W    = 40,
  parameter int HOLD_CYC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_vld_i,
  input  logic                    in_side_i,
  input  logic [QTY_W-1:0]        in_qty_i,
  input  logic [PX_W-1:0]         in_px_i,
  input  logic [TAG_W-1:0]        in_tag_i,
  input  logic [POS_W-1:0]        pos_limit_i,
  input  logic [EXP_W-1:0]        credit_limit_i,
  output logic                    rel_vld_o,
  output logic                    rel_side_o,
  output logic [QTY_W-1:0]        rel_qty_o,
  output logic [PX_W-1:0]         rel_px_o,
  output logic [TAG_W-1:0]        rel_tag_o,
  output logic signed [POS_W-1:0] rel_delta_o,
  output logic [EXP_W-1:0]        rel_ntl_o,
  output logic                    cxl_vld_o,
  output reason_e                 cxl_code_o,
  output logic [TAG_W-1:0]        cxl_tag_o
);
  localparam int LINE  = (HOLD_CYC > SLOW_LAT) ? HOLD_CYC : SLOW_LAT;
  localparam int VST   = SLOW_LAT - 1;  // stage feeding the verdict
  localparam bit LATE  = HOLD_CYC < SLOW_LAT;
  localparam int NTL_W = QTY_W + PX_W;

  logic                    st_vld   [1:LINE];
  logic                    st_side  [1:LINE];
  logic [QTY_W-1:0]        st_qty   [1:LINE];
  logic [PX_W-1:0]         st_px    [1:LINE];
  logic [TAG_W-1:0]        st_tag   [1:LINE];
  logic signed [POS_W-1:0] st_delta [1:LINE];
  logic [EXP_W-1:0]        st_ntl   [1:LINE];

  logic signed [POS_W-1:0] qty_ext, in_delta, proj_pos, new_pos;
  logic [NTL_W-1:0]        in_ntl;
  logic [EXP_W-1:0]        proj_exp;
  logic [EXP_W:0]          new_exp;
  logic [POS_W-1:0]        pos_mag;
  logic                    pos_bad, exp_bad, fail, kill, commit;
  reason_e                 fail_code;

  // stage 1 operands
  assign qty_ext  = $signed({{(POS_W-QTY_W){1'b0}}, in_qty_i});
  assign in_delta = in_side_i ? -qty_ext : qty_ext;
  assign in_ntl   = in_qty_i * in_px_i;

  // verdict on the entry leaving stage VST, against the running projection
  assign new_pos = proj_pos + st_delta[VST];
  assign new_exp = {1'b0, proj_exp} + {1'b0, st_ntl[VST]};
  assign pos_mag = new_pos[POS_W-1] ? $unsigned(-new_pos) : $unsigned(new_pos);
  assign pos_bad = pos_mag > pos_limit_i;
  assign exp_bad = new_exp > {1'b0, credit_limit_i};
  assign fail    = st_vld[VST] && (pos_bad || exp_bad);

  generate
    if (LATE) begin : g_late
      assign kill      = 1'b0;  // order already left: cannot revoke
      assign fail_code = RC_LATE;
    end else begin : g_held
      assign kill      = fail;
      assign fail_code = pos_bad ? RC_POS : RC_CREDIT;
    end
  endgenerate

  assign commit = st_vld[VST] && !kill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 1; k <= LINE; k++) begin
        st_vld[k]   <= 1'b0;
        st_side[k]  <= 1'b0;
        st_qty[k]   <= '0;
        st_px[k]    <= '0;
        st_tag[k]   <= '0;
        st_delta[k] <= '0;
        st_ntl[k]   <= '0;
      end
      proj_pos   <= '0;
      proj_exp   <= '0;
      cxl_vld_o  <= 1'b0;
      cxl_code_o <= RC_NONE;
      cxl_tag_o  <= '0;
    end else begin
      st_vld[1]   <= in_vld_i;
      st_side[1]  <= in_side_i;
      st_qty[1]   <= in_qty_i;
      st_px[1]    <= in_px_i;
      st_tag[1]   <= in_tag_i;
      st_delta[1] <= in_delta;
      st_ntl[1]   <= EXP_W'(in_ntl);
      for (int k = 2; k <= LINE; k++) begin
        st_vld[k]   <= (k == SLOW_LAT) ? (st_vld[k-1] && !kill) : st_vld[k-1];
        st_side[k]  <= st_side[k-1];
        st_qty[k]   <= st_qty[k-1];
        st_px[k]    <= st_px[k-1];
        st_tag[k]   <= st_tag[k-1];
        st_delta[k] <= st_delta[k-1];
        st_ntl[k]   <= st_ntl[k-1];
      end
      if (commit) begin
        proj_pos <= new_pos;
        proj_exp <= new_exp[EXP_W-1:0];
      end
      cxl_vld_o  <= fail;
      cxl_code_o <= fail_code;
      cxl_tag_o  <= st_tag[VST];
    end
  end

  assign rel_vld_o   = st_vld[HOLD_CYC];
  assign rel_side_o  = st_side[HOLD_CYC];
  assign rel_qty_o   = st_qty[HOLD_CYC];
  assign rel_px_o    = st_px[HOLD_CYC];
  assign rel_tag_o   = st_tag[HOLD_CYC];
  assign rel_delta_o = st_delta[HOLD_CYC];
  assign rel_ntl_o   = st_ntl[HOLD_CYC];
endmodule

// File: rtl/rg_ledger.sv
module rg_ledger #(
  parameter int POS_W = 24,
  parameter int EXP_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rel_vld_i,
  input  logic signed [POS_W-1:0] rel_delta_i,
  input  logic [EXP_W-1:0]        rel_ntl_i,
  output logic signed [POS_W-1:0] pos_o,
  output logic [EXP_W-1:0]        expo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o  <= '0;
      expo_o <= '0;
    end else if (rel_vld_i) begin
      pos_o  <= pos_o + rel_delta_i;
      expo_o <= expo_o + rel_ntl_i;
    end
  end
endmodule

// File: rtl/risk_gate.sv
module risk_gate
  import risk_gate_pkg::*;
#(
  parameter int QTY_W    = 16,
  parameter int PX_W     = 16,
  parameter int TAG_W    = 8,
  parameter int POS_W    = 24,
  parameter int EXP_W    = 40,
  parameter int HOLD_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ord_valid_i,
  input  logic             ord_side_i,
  input  logic [QTY_W-1:0] ord_qty_i,
  input  logic [PX_W-1:0]  ord_px_i,
  input  logic [TAG_W-1:0] ord_tag_i,
  input  logic [QTY_W-1:0] max_qty_i,
  input  logic [PX_W-1:0]  px_lo_i,
  input  logic [PX_W-1:0]  px_hi_i,
  input  logic [POS_W-1:0] pos_limit_i,
  input  logic [EXP_W-1:0] credit_limit_i,
  output logic             out_valid_o,
  output logic             out_side_o,
  output logic [QTY_W-1:0] out_qty_o,
  output logic [PX_W-1:0]  out_px_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic             rej_valid_o,
  output logic [2:0]       rej_code_o,
  output logic [TAG_W-1:0] rej_tag_o,
  output logic             cxl_valid_o,
  output logic [2:0]       cxl_code_o,
  output logic [TAG_W-1:0] cxl_tag_o,
  output logic [POS_W-1:0] pos_o,
  output logic [EXP_W-1:0] expo_o
);
  logic                    f_vld, f_side;
  logic [QTY_W-1:0]        f_qty;
  logic [PX_W-1:0]         f_px;
  logic [TAG_W-1:0]        f_tag;
  reason_e                 rej_code, cxl_code;
  logic signed [POS_W-1:0] rel_delta, pos_s;
  logic [EXP_W-1:0]        rel_ntl;

  rg_fast_check #(.QTY_W(QTY_W), .PX_W(PX_W), .TAG_W(TAG_W)) u_fast (
    .clk_i, .rst_ni,
    .ord_valid_i, .ord_side_i, .ord_qty_i, .ord_px_i, .ord_tag_i,
    .max_qty_i, .px_lo_i, .px_hi_i,
    .pass_vld_o(f_vld), .pass_side_o(f_side), .pass_qty_o(f_qty),
    .pass_px_o(f_px), .pass_tag_o(f_tag),
    .rej_vld_o(rej_valid_o), .rej_code_o(rej_code), .rej_tag_o(rej_tag_o)
  );

  rg_slow_line #(
    .QTY_W(QTY_W), .PX_W(PX_W), .TAG_W(TAG_W),
    .POS_W(POS_W), .EXP_W(EXP_W), .HOLD_CYC(HOLD_CYC)
  ) u_slow (
    .clk_i, .rst_ni,
    .in_vld_i(f_vld), .in_side_i(f_side), .in_qty_i(f_qty),
    .in_px_i(f_px), .in_tag_i(f_tag),
    .pos_limit_i, .credit_limit_i,
    .rel_vld_o(out_valid_o), .rel_side_o(out_side_o), .rel_qty_o(out_qty_o),
    .rel_px_o(out_px_o), .rel_tag_o(out_tag_o),
    .rel_delta_o(rel_delta), .rel_ntl_o(rel_ntl),
    .cxl_vld_o(cxl_valid_o), .cxl_code_o(cxl_code), .cxl_tag_o(cxl_tag_o)
  );

  rg_ledger #(.POS_W(POS_W), .EXP_W(EXP_W)) u_ledger (
    .clk_i, .rst_ni,
    .rel_vld_i(out_valid_o), .rel_delta_i(rel_delta), .rel_ntl_i(rel_ntl),
    .pos_o(pos_s), .expo_o(expo_o)
  );

  assign rej_code_o = rej_code;
  assign cxl_code_o = cxl_code;
  assign pos_o      = pos_s;
endmodule

// File: rtl/risk_gate_chk.sv
module risk_gate_chk
  import risk_gate_pkg::*;
#(
  parameter int QTY_W    = 16,
  parameter int PX_W     = 16,
  parameter int POS_W    = 24,
  parameter int EXP_W    = 40,
  parameter int HOLD_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [QTY_W-1:0] max_qty_i,
  input logic [PX_W-1:0]  px_lo_i,
  input logic [PX_W-1:0]  px_hi_i,
  input logic [POS_W-1:0] pos_limit_i,
  input logic [EXP_W-1:0] credit_limit_i,
  input logic             out_valid_o,
  input logic [QTY_W-1:0] out_qty_o,
  input logic [PX_W-1:0]  out_px_o,
  input logic             rej_valid_o,
  input logic [2:0]       rej_code_o,
  input logic             cxl_valid_o,
  input logic [2:0]       cxl_code_o,
  input logic [POS_W-1:0] pos_o,
  input logic [EXP_W-1:0] expo_o
);
  localparam bit LATE = HOLD_CYC < SLOW_LAT;

  logic [POS_W-1:0] pos_mag;
  assign pos_mag = pos_o[POS_W-1] ? (~pos_o + 1'b1) : pos_o;

  AST_REJ_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_valid_o |-> (rej_code_o == 3'd1 || rej_code_o == 3'd2)) else $error("rej code"); // R1
  AST_OUT_QTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_qty_o != '0 && out_qty_o <= max_qty_i)) else $error("out qty"); // R3
  AST_OUT_PX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_px_o >= px_lo_i && out_px_o <= px_hi_i)) else $error("out px"); // R2
  AST_EXP_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expo_o >= $past(expo_o)) else $error("exposure fell"); // R7
  AST_LEDGER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(out_valid_o) |-> ($stable(pos_o) && $stable(expo_o))) else $error("ledger moved"); // R7

  generate
    if (LATE) begin : g_late
      AST_CXL_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cxl_valid_o |-> cxl_code_o == 3'd5) else $error("late code"); // R8
    end else begin : g_held
      AST_CXL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cxl_valid_o |-> (cxl_code_o == 3'd3 || cxl_code_o == 3'd4)) else $error("cxl code"); // R4
      AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_mag <= pos_limit_i) else $error("position limit"); // R4
      AST_EXP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expo_o <= credit_limit_i) else $error("credit limit"); // R5
    end
  endgenerate
endmodule

bind risk_gate risk_gate_chk #(
  .QTY_W(QTY_W), .PX_W(PX_W), .POS_W(POS_W), .EXP_W(EXP_W), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .max_qty_i(max_qty_i), .px_lo_i(px_lo_i), .px_hi_i(px_hi_i),
  .pos_limit_i(pos_limit_i), .credit_limit_i(credit_limit_i),
  .out_valid_o(out_valid_o), .out_qty_o(out_qty_o), .out_px_o(out_px_o),
  .rej_valid_o(rej_valid_o), .rej_code_o(rej_code_o),
  .cxl_valid_o(cxl_valid_o), .cxl_code_o(cxl_code_o),
  .pos_o(pos_o), .expo_o(expo_o)
);

// File: tb/risk_gate_test.sv
module risk_gate_test;
  localparam int QW = 16, PW = 16, TW = 8, SW = 24, EW = 40;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          ord_valid = 1'b0, ord_side = 1'b0;
  logic [QW-1:0] ord_qty = '0, max_qty = 16'd100;
  logic [PW-1:0] ord_px = '0, px_lo = 16'd1000, px_hi = 16'd2000;
  logic [TW-1:0] ord_tag = '0;
  logic [SW-1:0] pos_limit = 24'd150;
  logic [EW-1:0] credit_limit = 40'd600000;

  logic          out_valid, out_side, rej_valid, cxl_valid;
  logic [QW-1:0] out_qty;
  logic [PW-1:0] out_px;
  logic [TW-1:0] out_tag, rej_tag, cxl_tag;
  logic [2:0]    rej_code, cxl_code;
  logic [SW-1:0] pos;
  logic [EW-1:0] expo;

  logic          s_out_valid, s_out_side, s_rej_valid, s_cxl_valid;
  logic [QW-1:0] s_out_qty;
  logic [PW-1:0] s_out_px;
  logic [TW-1:0] s_out_tag, s_rej_tag, s_cxl_tag;
  logic [2:0]    s_rej_code, s_cxl_code;
  logic [SW-1:0] s_pos;
  logic [EW-1:0] s_expo;

  int n_chk = 0, n_err = 0;
  longint m_pos = 0, m_exp = 0;

  always #4 clk = ~clk;

  risk_gate #(.QTY_W(QW), .PX_W(PW), .TAG_W(TW), .POS_W(SW), .EXP_W(EW), .HOLD_CYC(4)) uut (
    .clk_i(clk), .rst_ni,
    .ord_valid_i(ord_valid), .ord_side_i(ord_side), .ord_qty_i(ord_qty),
    .ord_px_i(ord_px), .ord_tag_i(ord_tag),
    .max_qty_i(max_qty), .px_lo_i(px_lo), .px_hi_i(px_hi),
    .pos_limit_i(pos_limit), .credit_limit_i(credit_limit),
    .out_valid_o(out_valid), .out_side_o(out_side), .out_qty_o(out_qty),
    .out_px_o(out_px), .out_tag_o(out_tag),
    .rej_valid_o(rej_valid), .rej_code_o(rej_code), .rej_tag_o(rej_tag),
    .cxl_valid_o(cxl_valid), .cxl_code_o(cxl_code), .cxl_tag_o(cxl_tag),
    .pos_o(pos), .expo_o(expo)
  );

  risk_gate #(.QTY_W(QW), .PX_W(PW), .TAG_W(TW), .POS_W(SW), .EXP_W(EW), .HOLD_CYC(2)) uut_short (
    .clk_i(clk), .rst_ni,
    .ord_valid_i(ord_valid), .ord_side_i(ord_side), .ord_qty_i(ord_qty),
    .ord_px_i(ord_px), .ord_tag_i(ord_tag),
    .max_qty_i(max_qty), .px_lo_i(px_lo), .px_hi_i(px_hi),
    .pos_limit_i(pos_limit), .credit_limit_i(credit_limit),
    .out_valid_o(s_out_valid), .out_side_o(s_out_side), .out_qty_o(s_out_qty),
    .out_px_o(s_out_px), .out_tag_o(s_out_tag),
    .rej_valid_o(s_rej_valid), .rej_code_o(s_rej_code), .rej_tag_o(s_rej_tag),
    .cxl_valid_o(s_cxl_valid), .cxl_code_o(s_cxl_code), .cxl_tag_o(s_cxl_tag),
    .pos_o(s_pos), .expo_o(s_expo)
  );

  // {side, qty, px, expected code}; code 0 = released
  localparam logic [35:0] VEC [13] = '{
    {1'b0, 16'd50,  16'd1500, 3'd0},
    {1'b0, 16'd0,   16'd1500, 3'd1},
    {1'b0, 16'd101, 16'd1500, 3'd1},
    {1'b1, 16'd10,  16'd999,  3'd2},
    {1'b0, 16'd10,  16'd2001, 3'd2},
    {1'b0, 16'd100, 16'd2000, 3'd0},
    {1'b0, 16'd1,   16'd1000, 3'd3},
    {1'b1, 16'd100, 16'd1000, 3'd0},
    {1'b1, 16'd100, 16'd1100, 3'd0},
    {1'b1, 16'd100, 16'd1200, 3'd4},
    {1'b0, 16'd10,  16'd1000, 3'd0},
    {1'b0, 16'd101, 16'd500,  3'd1},
    {1'b0, 16'd100, 16'd1050, 3'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic s, input logic [QW-1:0] q, input logic [PW-1:0] p,
                       input logic [TW-1:0] t);
    @(negedge clk);
    ord_valid = 1'b1; ord_side = s; ord_qty = q; ord_px = p; ord_tag = t;
    @(negedge clk);
    ord_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [SW-1:0] pl, input logic [EW-1:0] cl);
    @(negedge clk);
    rst_ni = 1'b0; pos_limit = pl; credit_limit = cl;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", out_valid, 0);
    chk("R9 rej_valid", rej_valid, 0);
    chk("R9 cxl_valid", cxl_valid, 0);
    chk("R9 pos", pos, 0);
    chk("R9 expo", expo, 0);

    for (int i = 0; i < 13; i++) begin
      logic [35:0] v;
      logic [2:0]  c;
      string rq;
      v = VEC[i];
      c = v[2:0];
      drive(v[35], v[34:19], v[18:3], TW'(i + 1));
      rq = (c == 3'd2) ? "R2" : "R1";
      chk(rq, rej_valid, (c == 3'd1 || c == 3'd2));
      if (c == 3'd1 || c == 3'd2) begin
        chk(rq, rej_code, c);
        chk(rq, rej_tag, i + 1);
      end
      repeat (3) @(negedge clk);
      rq = (c == 3'd4) ? "R5" : "R4";
      chk(rq, cxl_valid, (c == 3'd3 || c == 3'd4));
      if (c == 3'd3 || c == 3'd4) begin
        chk(rq, cxl_code, c);
        chk(rq, cxl_tag, i + 1);
      end
      @(negedge clk);
      chk("R3 out_valid", out_valid, (c == 3'd0));
      if (c == 3'd0) begin
        chk("R3 side", out_side, v[35]);
        chk("R3 qty", out_qty, v[34:19]);
        chk("R3 px", out_px, v[18:3]);
        chk("R3 tag", out_tag, i + 1);
        m_pos += v[35] ? -longint'(v[34:19]) : longint'(v[34:19]);
        m_exp += longint'(v[34:19]) * longint'(v[18:3]);
      end
      @(negedge clk);
      chk("R7 pos", 64'($signed(pos)), m_pos);
      chk("R7 expo", expo, m_exp);
    end

    // R6 back-to-back orders, second sees first in projection
    do_reset(24'd150, 40'd600000);
    @(negedge clk);
    ord_valid = 1'b1; ord_side = 1'b0; ord_qty = 16'd100; ord_px = 16'd1000; ord_tag = 8'd20;
    @(negedge clk);
    ord_tag = 8'd21;
    @(negedge clk);
    ord_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 first not cancelled", cxl_valid, 0);
    @(negedge clk);
    chk("R6 first released", out_valid, 1);
    chk("R6 first tag", out_tag, 20);
    chk("R6 second cancelled", cxl_valid, 1);
    chk("R6 second code", cxl_code, 3);
    chk("R6 second tag", cxl_tag, 21);
    @(negedge clk);
    chk("R6 second withheld", out_valid, 0);
    chk("R7 pos after pair", pos, 100);

    // R5 both limits broken: position code wins
    do_reset(24'd10, 40'd50000);
    drive(1'b0, 16'd100, 16'd1000, 8'd40);
    chk("R5 no fast reject", rej_valid, 0);
    repeat (3) @(negedge clk);
    chk("R5 cancel", cxl_valid, 1);
    chk("R5 priority code", cxl_code, 3);
    repeat (2) @(negedge clk);
    chk("R7 pos untouched", pos, 0);
    chk("R7 expo untouched", expo, 0);

    // R8 late verdict on short hold line; R4 withheld on full hold line
    do_reset(24'd50, 40'd600000);
    drive(1'b0, 16'd100, 16'd1000, 8'd30);
    @(negedge clk);
    @(negedge clk);
    chk("R8 short released", s_out_valid, 1);
    chk("R8 short tag", s_out_tag, 30);
    @(negedge clk);
    chk("R8 late flag", s_cxl_valid, 1);
    chk("R8 late code", s_cxl_code, 5);
    chk("R8 late tag", s_cxl_tag, 30);
    chk("R8 released order counted", s_pos, 100);
    chk("R4 held cancel code", cxl_code, 3);
    @(negedge clk);
    chk("R4 held withheld", out_valid, 0);
    chk("R8 late order kept", s_expo, 100000);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule